// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block is the timekeeping core of a real-time clock. A divider turns a base rate enable into a once-per-second advance. That advance steps seconds, minutes and hours. A day carry then steps the day of month, the weekday, the month and the two-digit year. Every field is held as packed BCD. Hours can run in 24-hour form or in 12-hour form with an afternoon bit. February takes a 29th day in every year whose two-digit value is a multiple of four.

A bus agent outside the block freezes counting while it reads or writes the time. One second that falls due during the freeze is held back and applied on release; any further seconds in the same freeze are dropped. A stop control clears the divider and holds it, so the time can be loaded and released on an exact second boundary. Single-cycle strobes load individual time or alarm fields from a shared data byte.

Four alarm fields (minute, hour, day, weekday) are compared against the running time. Bit 7 of each alarm field is an active-low enable. The alarm flag is raised when the time steps into a state that matches every enabled field. It stays raised until it is cleared, and it only rises again after a new step into a match. Pulses mark each second step and each minute step, and an oscillator-fail flag rides in bit 7 of the seconds output.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes are BCD 00..59; a step at second 59 returns seconds to 00 and steps the minute, and minute 59 wraps to 00 with an hour step.
- R2: With twelve_hr_i low, hours are BCD 00..23 in bits 5:0, and a step from 23:59:59 gives 00:00:00 and advances the day.
- R3: With twelve_hr_i high, hour bits 4:0 hold BCD 01..12 and bit 5 is the afternoon bit; 12 steps to 01, 11 steps to 12 with bit 5 inverted, and the day advances only on the 11 PM to 12 AM step.
- R4: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11 and after day 31 in the other non-February months; month 12 wraps to 01 with a year step, year 99 wraps to 00, and the weekday (0..6 in bits 2:0) steps with each day and wraps 6 to 0.
- R5: February ends on day 29 when the two-digit year is divisible by four (00 included) and on day 28 otherwise.
- R6: While freeze_i is high no time field advances; if at least one second falls due during the freeze, exactly one second is applied in the first cycle after freeze_i falls.
- R7: stop_i clears and holds the divider; after it falls, the first second step happens on exactly the PRESC_DIV-th base_tick_i cycle.
- R8: ld_time_i bit 0..6 loads seconds, minutes, hours, day, weekday, month, year from ld_data_i on the next edge; ld_alarm_i bit 0..3 loads the minute, hour, day, weekday alarm field; other fields are untouched.
- R9: sec_o bit 7 is the oscillator-fail flag: 1 after reset, set by osc_fail_i, written from ld_data_i bit 7 by a seconds load.
- R10: An alarm field takes part in the comparison when its bit 7 is 0; with at least one field enabled and all enabled fields equal to the time, a time step sets alarm_flag_o one cycle after the new time appears.
- R11: alarm_flag_o stays set until alarm_clr_i; remaining in a matching state, or being loaded into one, does not set it again.
- R12: sec_evt_o pulses for one cycle with each second step and min_evt_o with each minute step, both in the cycle the new value first shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Base rate enable fed to the divider |
| stop_i | input | 1 | Clear and hold the divider |
| freeze_i | input | 1 | Suspend counting during a bus access |
| twelve_hr_i | input | 1 | 1 selects 12-hour form |
| osc_fail_i | input | 1 | Sets the oscillator-fail flag |
| ld_time_i | input | 7 | Per-field time load strobes |
| ld_alarm_i | input | 4 | Per-field alarm load strobes |
| ld_data_i | input | 8 | Shared load data |
| alarm_clr_i | input | 1 | Clears the alarm flag |
| sec_o | output | 8 | Oscillator-fail flag and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours, bit 5 afternoon in 12-hour form |
| day_o | output | 8 | BCD day of month |
| wday_o | output | 8 | Weekday 0..6 |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD two-digit year |
| alarm_flag_o | output | 1 | Alarm flag |
| sec_evt_o | output | 1 | Second step pulse |
| min_evt_o | output | 1 | Minute step pulse |

## Verification
The bench sweeps every month of all hundred years across both the last and second-to-last day. A wrong month length or leap rule then shows up as a day that wraps early or runs one too far. Every hour value is stepped in both hour forms, which catches an afternoon bit that flips at 12 instead of 11 or a day carry on the wrong edge. Freeze and stop are driven across second boundaries. A freeze that loses the held second, or replays every missed one, gives the wrong second count. A divider that keeps its partial count through stop steps early. The alarm runs through match entry, clear, staying in the match and loading into a match. A flag driven by level rather than by entry would rise again after the clear.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] hour;
    logic       roll;
  } hour_step_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    int yv;
    yv = int'(yr[7:4]) * 10 + int'(yr[3:0]);
    if (mon == 8'h02) return ((yv % 4) == 0) ? 8'h29 : 8'h28;
    if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
    return 8'h31;
  endfunction

  function automatic hour_step_t hour_step(input logic [7:0] h, input logic twelve);
    hour_step_t r;
    logic [7:0] v;
    r.roll = 1'b0;
    v = h & 8'h1F;
    if (!twelve) begin
      if (h == 8'h23) begin
        r.hour = 8'h00;
        r.roll = 1'b1;
      end else begin
        r.hour = bcd_inc(h);
      end
    end else if (v == 8'h12) begin
      r.hour = {2'b00, h[5], 5'h01};
    end else if (v == 8'h11) begin
      r.hour = {2'b00, ~h[5], 5'h12};
      r.roll = h[5];
    end else begin
      r.hour = bcd_inc(v) | {2'b00, h[5], 5'h00};
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic base_tick_i,
  input  logic stop_i,
  output logic sec_pulse_o
);
  localparam int CW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESC_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (stop_i) begin
      cnt_q <= '0;
    end else if (base_tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end

  assign sec_pulse_o = base_tick_i && !stop_i && (cnt_q == LAST);
endmodule

// File: rtl/rtc_tick_hold.sv
module rtc_tick_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_pulse_i,
  input  logic freeze_i,
  output logic adv_o,
  output logic pending_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (freeze_i) pend_q <= pend_q | sec_pulse_i;
    else pend_q <= 1'b0;
  end

  assign adv_o     = !freeze_i && (sec_pulse_i || pend_q);
  assign pending_o = pend_q;
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       twelve_hr_i,
  input  logic       osc_fail_i,
  input  logic [6:0] ld_time_i,
  input  logic [7:0] ld_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] wday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       sec_wrap_o
);
  logic       os_q;
  logic [7:0] sec_q, min_q, hour_q, day_q, wday_q, mon_q, year_q;
  hour_step_t hs;
  logic [7:0] dim;
  logic       sec_wrap, min_wrap, day_step, mon_step, year_step;

  assign hs        = hour_step(hour_q, twelve_hr_i);
  assign dim       = month_days(mon_q, year_q);
  assign sec_wrap  = adv_i && (sec_q == 8'h59);
  assign min_wrap  = sec_wrap && (min_q == 8'h59);
  assign day_step  = min_wrap && hs.roll;
  assign mon_step  = day_step && (day_q == dim);
  assign year_step = mon_step && (mon_q == 8'h12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      os_q   <= 1'b1;
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      day_q  <= 8'h01;
      wday_q <= 8'h00;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      if (osc_fail_i) os_q <= 1'b1;
      else if (ld_time_i[0]) os_q <= ld_data_i[7];

      if (ld_time_i[0]) sec_q <= ld_data_i & 8'h7F;
      else if (adv_i) sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);

      if (ld_time_i[1]) min_q <= ld_data_i & 8'h7F;
      else if (sec_wrap) min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);

      if (ld_time_i[2]) hour_q <= ld_data_i & 8'h3F;
      else if (min_wrap) hour_q <= hs.hour;

      if (ld_time_i[3]) day_q <= ld_data_i & 8'h3F;
      else if (day_step) day_q <= mon_step ? 8'h01 : bcd_inc(day_q);

      if (ld_time_i[4]) wday_q <= ld_data_i & 8'h07;
      else if (day_step) wday_q <= (wday_q == 8'h06) ? 8'h00 : wday_q + 8'h01;

      if (ld_time_i[5]) mon_q <= ld_data_i & 8'h1F;
      else if (mon_step) mon_q <= year_step ? 8'h01 : bcd_inc(mon_q);

      if (ld_time_i[6]) year_q <= ld_data_i;
      else if (year_step) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign sec_o      = sec_q | {os_q, 7'h00};
  assign min_o      = min_q;
  assign hour_o     = hour_q;
  assign day_o      = day_q;
  assign wday_o     = wday_q;
  assign mon_o      = mon_q;
  assign year_o     = year_q;
  assign sec_wrap_o = sec_wrap;
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int NFIELD = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFIELD-1:0] ld_alarm_i,
  input  logic [7:0]        ld_data_i,
  input  logic [7:0]        cur_i [NFIELD],
  input  logic              step_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              hit_o
);
  logic [7:0]        alm_q [NFIELD];
  logic [NFIELD-1:0] ok, en;
  logic              match, match_q, flag_q;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alm_q[g] <= 8'h80;
      else if (ld_alarm_i[g]) alm_q[g] <= ld_data_i;
    end
    assign en[g] = !alm_q[g][7];
    assign ok[g] = !en[g] || ({1'b0, alm_q[g][6:0]} == cur_i[g]);
  end

  assign match = (|en) && (&ok);
  assign hit_o = step_i && match && !match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= match;
      if (hit_o) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int PRESC_DIV = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       base_tick_i,
  input  logic       stop_i,
  input  logic       freeze_i,
  input  logic       twelve_hr_i,
  input  logic       osc_fail_i,
  input  logic [6:0] ld_time_i,
  input  logic [3:0] ld_alarm_i,
  input  logic [7:0] ld_data_i,
  input  logic       alarm_clr_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] day_o,
  output logic [7:0] wday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       alarm_flag_o,
  output logic       sec_evt_o,
  output logic       min_evt_o
);
  localparam int NALARM = 4;

  logic       sec_pulse_w, adv_w, pending_w, sec_wrap_w, alarm_hit_w;
  logic       sec_evt_q, min_evt_q;
  logic [7:0] cur_w [NALARM];

  rtc_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_tick_i(base_tick_i),
    .stop_i(stop_i), .sec_pulse_o(sec_pulse_w)
  );

  rtc_tick_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_pulse_i(sec_pulse_w),
    .freeze_i(freeze_i), .adv_o(adv_w), .pending_o(pending_w)
  );

  rtc_time_chain u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_w), .twelve_hr_i(twelve_hr_i),
    .osc_fail_i(osc_fail_i), .ld_time_i(ld_time_i), .ld_data_i(ld_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .wday_o(wday_o), .mon_o(mon_o), .year_o(year_o), .sec_wrap_o(sec_wrap_w)
  );

  assign cur_w[0] = min_o;
  assign cur_w[1] = hour_o;
  assign cur_w[2] = day_o;
  assign cur_w[3] = wday_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_evt_q <= 1'b0;
      min_evt_q <= 1'b0;
    end else begin
      sec_evt_q <= adv_w;
      min_evt_q <= sec_wrap_w;
    end
  end

  rtc_alarm_unit #(.NFIELD(NALARM)) u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_alarm_i(ld_alarm_i), .ld_data_i(ld_data_i),
    .cur_i(cur_w), .step_i(sec_evt_q), .clr_i(alarm_clr_i),
    .flag_o(alarm_flag_o), .hit_o(alarm_hit_w)
  );

  assign sec_evt_o = sec_evt_q;
  assign min_evt_o = min_evt_q;
endmodule

// File: rtl/rtc_calendar_checks.sv
module rtc_calendar_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       freeze_i,
  input logic       stop_i,
  input logic [6:0] ld_time_i,
  input logic       alarm_clr_i,
  input logic [7:0] sec_o,
  input logic       alarm_flag_o,
  input logic       min_evt_o,
  input logic       adv_w,
  input logic       pending_w,
  input logic       sec_pulse_w,
  input logic       alarm_hit_w
);
  // R6: no second step while frozen
  a_r6_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && ld_time_i == 7'd0) |=> $stable(sec_o[6:0]));
  // R6: a second due during freeze is remembered
  a_r6_pending_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && sec_pulse_w) |=> pending_w);
  // R6: the held second is consumed on release
  a_r6_pending_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_w && !freeze_i) |=> !pending_w);
  // R7: stopped divider produces no step
  a_r7_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !freeze_i && !pending_w && ld_time_i == 7'd0) |=> $stable(sec_o[6:0]));
  // R10: a fresh match raises the flag
  a_r10_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit_w |=> alarm_flag_o);
  // R11: flag holds until cleared
  a_r11_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_flag_o && !alarm_clr_i) |=> alarm_flag_o);
  // R11: clear drops the flag
  a_r11_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_clr_i && !alarm_hit_w) |=> !alarm_flag_o);
  // R12: minute step shows seconds 00
  a_r12_min_evt_zero_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_evt_o && !adv_w) |-> sec_o[6:0] == 7'h00);
endmodule

bind rtc_calendar_core rtc_calendar_checks u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .freeze_i(freeze_i), .stop_i(stop_i),
  .ld_time_i(ld_time_i), .alarm_clr_i(alarm_clr_i), .sec_o(sec_o),
  .alarm_flag_o(alarm_flag_o), .min_evt_o(min_evt_o), .adv_w(adv_w),
  .pending_w(pending_w), .sec_pulse_w(sec_pulse_w), .alarm_hit_w(alarm_hit_w)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic base_tick = 0, stop = 0, freeze = 0, twelve = 0, osc_fail = 0, aclr = 0;
  logic [6:0] ld_time = '0;
  logic [3:0] ld_alarm = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] sec_o, min_o, hour_o, day_o, wday_o, mon_o, year_o;
  logic aflag, sec_evt, min_evt;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rtc_calendar_core #(.PRESC_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .base_tick_i(base_tick), .stop_i(stop),
    .freeze_i(freeze), .twelve_hr_i(twelve), .osc_fail_i(osc_fail),
    .ld_time_i(ld_time), .ld_alarm_i(ld_alarm), .ld_data_i(ld_data),
    .alarm_clr_i(aclr), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .day_o(day_o), .wday_o(wday_o), .mon_o(mon_o), .year_o(year_o),
    .alarm_flag_o(aflag), .sec_evt_o(sec_evt), .min_evt_o(min_evt)
  );

  function automatic logic [7:0] b(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int dim_of(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ldt(input int idx, input logic [7:0] d);
    ld_time = 7'(1 << idx);
    ld_data = d;
    @(negedge clk);
    ld_time = '0;
  endtask

  task automatic lda(input int idx, input logic [7:0] d);
    ld_alarm = 4'(1 << idx);
    ld_data = d;
    @(negedge clk);
    ld_alarm = '0;
  endtask

  task automatic base(input int n);
    base_tick = 1'b1;
    repeat (n) @(negedge clk);
    base_tick = 1'b0;
  endtask

  task automatic clear_flag();
    aclr = 1'b1;
    @(negedge clk);
    aclr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state, R8 reset field values
    chk("R9 reset os", 32'(sec_o), 32'h80);
    chk("R8 reset min", 32'(min_o), 32'h00);
    chk("R8 reset day", 32'(day_o), 32'h01);
    chk("R8 reset mon", 32'(mon_o), 32'h01);
    chk("R10 reset flag", 32'(aflag), 32'h0);

    // R9 oscillator flag
    ldt(0, 8'h00);
    chk("R9 os cleared by load", 32'(sec_o), 32'h00);
    osc_fail = 1'b1; @(negedge clk); osc_fail = 1'b0;
    chk("R9 os set by fail", 32'(sec_o), 32'h80);
    ldt(0, 8'h05);
    chk("R9 os load", 32'(sec_o), 32'h05);

    // R8 single-field load leaves others alone
    ldt(4, 8'h05);
    chk("R8 wday load", 32'(wday_o), 32'h05);
    chk("R8 sec untouched", 32'(sec_o), 32'h05);

    // R1 R12 continuous sweep in 24-hour form
    ldt(0, 8'h00); ldt(1, 8'h00); ldt(2, 8'h00);
    for (int t = 1; t <= 3700; t++) begin
      base(DIV);
      chk("R1 sec", 32'(sec_o), 32'(b(t % 60)));
      chk("R1 min", 32'(min_o), 32'(b((t / 60) % 60)));
      chk("R2 hour", 32'(hour_o), 32'(b(t / 3600)));
      chk("R12 sec_evt", 32'(sec_evt), 32'h1);
      chk("R12 min_evt", 32'(min_evt), 32'((t % 60) == 0));
    end
    @(negedge clk);
    chk("R12 sec_evt single", 32'(sec_evt), 32'h0);

    // R2 every hour step in 24-hour form
    for (int h = 0; h < 24; h++) begin
      ldt(3, 8'h10); ldt(2, b(h)); ldt(1, 8'h59); ldt(0, 8'h59);
      base(DIV);
      chk("R2 next hour", 32'(hour_o), 32'(b((h + 1) % 24)));
      chk("R2 day carry", 32'(day_o), 32'(h == 23 ? 8'h11 : 8'h10));
    end

    // R3 every hour step in 12-hour form
    twelve = 1'b1;
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh, npm;
        nh = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        ldt(3, 8'h10); ldt(2, b(h) | 8'(pm << 5)); ldt(1, 8'h59); ldt(0, 8'h59);
        base(DIV);
        chk("R3 12h hour", 32'(hour_o), 32'(b(nh) | 8'(npm << 5)));
        chk("R3 12h day", 32'(day_o), 32'((h == 11 && pm == 1) ? 8'h11 : 8'h10));
      end
    end
    twelve = 1'b0;

    // R4 R5 month ends across all years
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d, w;
        d = dim_of(m, y);
        w = (y * 12 + m) % 7;
        ldt(6, b(y)); ldt(5, b(m)); ldt(3, b(d - 1)); ldt(4, 8'(w));
        ldt(2, 8'h23); ldt(1, 8'h59); ldt(0, 8'h59);
        base(DIV);
        chk(m == 2 ? "R5 feb not yet over" : "R4 month not yet over", 32'(day_o), 32'(b(d)));
        chk("R4 month kept", 32'(mon_o), 32'(b(m)));
        ldt(2, 8'h23); ldt(1, 8'h59); ldt(0, 8'h59);
        base(DIV);
        chk(m == 2 ? "R5 feb wrap" : "R4 day wrap", 32'(day_o), 32'h01);
        chk("R4 month step", 32'(mon_o), 32'(b(m == 12 ? 1 : m + 1)));
        chk("R4 year step", 32'(year_o), 32'(b(m == 12 ? (y + 1) % 100 : y)));
        chk("R4 weekday", 32'(wday_o), 32'((w + 2) % 7));
      end
    end

    // R6 freeze with two due seconds gives one
    ldt(2, 8'h12); ldt(1, 8'h00); ldt(0, 8'h00);
    freeze = 1'b1;
    base(2 * DIV);
    chk("R6 frozen", 32'(sec_o), 32'h00);
    freeze = 1'b0;
    @(negedge clk);
    chk("R6 one held second", 32'(sec_o), 32'h01);
    repeat (3) @(negedge clk);
    chk("R6 no replay", 32'(sec_o), 32'h01);
    freeze = 1'b1; repeat (3) @(negedge clk); freeze = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 empty freeze", 32'(sec_o), 32'h01);

    // R7 stop clears divider
    base(2);
    stop = 1'b1;
    base(9);
    chk("R7 stopped", 32'(sec_o), 32'h01);
    stop = 1'b0;
    base(DIV - 1);
    chk("R7 not early", 32'(sec_o), 32'h01);
    base(1);
    chk("R7 exact restart", 32'(sec_o), 32'h02);

    // R10 R11 alarm
    lda(0, 8'h30); lda(1, 8'h08); lda(2, 8'h80); lda(3, 8'h80);
    ldt(3, 8'h15); ldt(2, 8'h08); ldt(1, 8'h29); ldt(0, 8'h58);
    base(DIV); @(negedge clk);
    chk("R10 no match yet", 32'(aflag), 32'h0);
    base(DIV);
    chk("R10 flag one cycle later", 32'(aflag), 32'h0);
    @(negedge clk);
    chk("R10 flag set", 32'(aflag), 32'h1);
    base(DIV); @(negedge clk);
    chk("R11 flag held", 32'(aflag), 32'h1);
    clear_flag();
    chk("R11 cleared", 32'(aflag), 32'h0);
    base(DIV); @(negedge clk);
    chk("R11 no refire in match", 32'(aflag), 32'h0);
    ldt(1, 8'h31); ldt(1, 8'h30); repeat (2) @(negedge clk);
    chk("R11 load into match", 32'(aflag), 32'h0);
    ldt(1, 8'h29); ldt(0, 8'h59);
    base(DIV); @(negedge clk);
    chk("R11 fresh entry", 32'(aflag), 32'h1);
    clear_flag();
    lda(2, 8'h16);
    ldt(1, 8'h29); ldt(0, 8'h59);
    base(DIV); @(negedge clk);
    chk("R10 day mismatch", 32'(aflag), 32'h0);
    ldt(3, 8'h16); ldt(1, 8'h29); ldt(0, 8'h59);
    base(DIV); @(negedge clk);
    chk("R10 day match", 32'(aflag), 32'h1);
    clear_flag();
    lda(0, 8'h80); lda(1, 8'h80); lda(2, 8'h80);
    ldt(1, 8'h29); ldt(0, 8'h59);
    base(DIV); @(negedge clk);
    chk("R10 all disabled", 32'(aflag), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule